// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block decides which of a set of interrupt sources is handed to the CPU and when. Each source has a pending flag, which a one-cycle `req_set` pulse sets. Each source also has a mask bit and a 2-bit priority code. Code 0 is the most urgent level and code 3 the least urgent. A small stack records the priority levels that are currently in service. A new request can interrupt a running handler only if its code is strictly lower than the code on top of that stack. It also needs the global interrupt-enable flag to be set.

Four one-cycle strobes from the CPU side drive the enable flag and the stack:

- enable-interrupts sets the enable flag.
- disable-interrupts clears the enable flag.
- return-from-interrupt pops the stack and sets the enable flag.
- instruction-retired releases the block after a return.

Every acknowledge clears the enable flag, so a handler must re-enable explicitly before it can be nested. After any return, the block holds off all acknowledges until one instruction has retired in the resumed context.

All outputs are registered. The acknowledge pulse, source index, cleared pending flag, cleared enable flag and new in-service level all appear together after the clock edge that takes the decision.

Top module: `nest_irq_ctrl`

## Requirements
- R1: Among pending, unmasked, eligible sources, the one with the smallest 2-bit priority code (bits [2i+1:2i] of `src_prio` for source i) wins. On equal codes the smallest source index wins.
- R2: An acknowledge is a one-cycle `ack` pulse carrying the winner on `ack_src`. After that edge `ie` is 0 and the winner's bit in `pend` is cleared.
- R3: No acknowledge is made while `ie` is 0. An `ei_stb` pulse sets `ie` to 1 at the next edge.
- R4: With no level in service, any code is eligible. With a level in service, only a strictly smaller code is acknowledged. Equal or larger codes stay pending.
- R5: The in-service stack holds up to 4 levels. `svc_level` shows the top entry and `svc_valid` is 0 when the stack is empty. A return pops one entry and restores the level of the interrupted context.
- R6: A `reti_stb` pulse leaves `ie` at 1 after its edge, unless `di_stb` is also present.
- R7: No acknowledge happens at the edge of a return. After a return, no acknowledge happens until a `retire_stb` has been seen. The earliest acknowledge comes at the edge after the one that takes the retire strobe.
- R8: A masked source is never acknowledged, and its `pend` bit stays set.
- R9: `di_stb` clears `ie` at the next edge. It takes precedence over `ei_stb` and `reti_stb`, and it blocks an acknowledge in the same cycle.
- R10: Synchronous reset clears `ack`, `ie`, the stack (`svc_valid` = 0) and every pending flag.
- R11: A `req_set` bit sets the matching `pend` bit at the next edge. The bit stays set until that source is acknowledged or the block is reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_set | input | NSRC | One-cycle pulses that set pending flags |
| src_mask | input | NSRC | 1 = source may not be acknowledged |
| src_prio | input | NSRC*PRIO_W | Priority code per source, source i at [PRIO_W*i +: PRIO_W] |
| ei_stb | input | 1 | Enable-interrupts strobe |
| di_stb | input | 1 | Disable-interrupts strobe |
| reti_stb | input | 1 | Return-from-interrupt strobe |
| retire_stb | input | 1 | Instruction-retired strobe |
| ack | output | 1 | Acknowledge pulse |
| ack_src | output | IDX_W | Index of the acknowledged source |
| ie | output | 1 | Global interrupt-enable flag |
| svc_valid | output | 1 | At least one level is in service |
| svc_level | output | PRIO_W | Priority code on top of the in-service stack |
| pend | output | NSRC | Pending request flags |

## Verification
Some properties are checked by the assertions on every cycle:

- An acknowledge never follows a cycle in which the enable flag was clear.
- An acknowledge never follows a return strobe, a masked source, or a disable strobe.
- Each acknowledge pushes a strictly more urgent level.
- The enable flag is clear right after an acknowledge.
- The stack never exceeds its depth.

The bench scenarios show what a single cycle cannot:

- the full winner selection over every request and mask pattern;
- pending requests that survive an equal-or-lower priority comparison;
- the exact release edge after the retire strobe;
- level restoration across four nested returns.

// File: rtl/nirq_pkg.sv
package nirq_pkg;

  // Width of a priority code; level 0 is the most urgent.
  localparam int PRIO_W = 2;
  localparam int LEVELS = 1 << PRIO_W;

  typedef logic [PRIO_W-1:0] prio_t;

  // Enable state updates, ordered by precedence.
  typedef enum logic [1:0] {
    IE_KEEP  = 2'd0,
    IE_SET   = 2'd1,
    IE_CLEAR = 2'd2
  } ie_op_e;

  // True when a candidate code may preempt the level in service.
  function automatic logic may_preempt(input prio_t cand, input prio_t cur,
                                       input logic cur_valid);
    return !cur_valid || (cand < cur);
  endfunction

  // True when candidate a should replace the current best b.
  function automatic logic beats(input prio_t a, input prio_t b,
                                 input logic have_b);
    return !have_b || (a < b);
  endfunction

  // Next enable operation from the event strobes of one cycle.
  function automatic ie_op_e ie_decide(input logic grant, input logic dis,
                                       input logic en, input logic ret);
    if (grant || dis) return IE_CLEAR;
    if (en || ret) return IE_SET;
    return IE_KEEP;
  endfunction

endpackage

// File: rtl/nirq_arbiter.sv
module nirq_arbiter
  import nirq_pkg::*;
#(
  parameter int NSRC  = 8,
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]        pend,
  input  logic [NSRC-1:0]        mask,
  input  logic [NSRC*PRIO_W-1:0] prio_flat,
  input  logic                   cur_valid,
  input  prio_t                  cur_level,
  output logic                   win_valid,
  output logic [IDX_W-1:0]       win_idx,
  output prio_t                  win_prio
);

  prio_t            prio_a [NSRC];
  logic [NSRC-1:0]  elig;

  // Per-source eligibility: pending, unmasked, and more urgent than service.
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign prio_a[g] = prio_flat[g*PRIO_W +: PRIO_W];
    assign elig[g]   = pend[g] && !mask[g] &&
                       may_preempt(prio_a[g], cur_level, cur_valid);
  end

  // Ascending scan with strict compare keeps the lowest index on ties.
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_prio  = '1;
    for (int i = 0; i < NSRC; i++) begin
      if (elig[i] && beats(prio_a[i], win_prio, win_valid)) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
        win_prio  = prio_a[i];
      end
    end
  end

endmodule

// File: rtl/nirq_level_stack.sv
module nirq_level_stack
  import nirq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  prio_t            push_level,
  input  logic             pop,
  output logic             top_valid,
  output prio_t            top_level,
  output logic             full,
  output logic [CNT_W-1:0] depth
);

  prio_t            lvl_q [DEPTH];
  logic [CNT_W-1:0] sp_q;
  logic             do_push;
  logic             do_pop;

  assign full    = (sp_q == CNT_W'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !push && (sp_q != '0);

  always_ff @(posedge clk) begin
    if (rst)          sp_q <= '0;
    else if (do_push) sp_q <= sp_q + 1'b1;
    else if (do_pop)  sp_q <= sp_q - 1'b1;
  end

  // One register per slot, written only when the pointer selects it.
  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)                                     lvl_q[e] <= '1;
      else if (do_push && sp_q == CNT_W'(e))       lvl_q[e] <= push_level;
    end
  end

  always_comb begin
    top_level = '1;
    for (int e = 0; e < DEPTH; e++) begin
      if (sp_q == CNT_W'(e + 1)) top_level = lvl_q[e];
    end
  end

  assign top_valid = (sp_q != '0);
  assign depth     = sp_q;

  logic unused_slot;
  assign unused_slot = ^SLOT_W;

endmodule

// File: rtl/nirq_enable_ctrl.sv
module nirq_enable_ctrl
  import nirq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic grant,
  input  logic ei_stb,
  input  logic di_stb,
  input  logic reti_stb,
  input  logic retire_stb,
  output logic ie,
  output logic hold
);

  ie_op_e op;
  logic   ie_q;
  logic   hold_q;

  assign op = ie_decide(grant, di_stb, ei_stb, reti_stb);

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q <= 1'b0;
    end else begin
      unique case (op)
        IE_CLEAR: ie_q <= 1'b0;
        IE_SET:   ie_q <= 1'b1;
        default:  ie_q <= ie_q;
      endcase
    end
  end

  // After a return, hold every acknowledge until one instruction retires.
  always_ff @(posedge clk) begin
    if (rst)                     hold_q <= 1'b0;
    else if (reti_stb)           hold_q <= 1'b1;
    else if (retire_stb)         hold_q <= 1'b0;
  end

  assign ie   = ie_q;
  assign hold = hold_q;

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nirq_pkg::*;
#(
  parameter int NSRC  = 8,
  parameter int DEPTH = 4,
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NSRC-1:0]        req_set,
  input  logic [NSRC-1:0]        src_mask,
  input  logic [NSRC*PRIO_W-1:0] src_prio,
  input  logic                   ei_stb,
  input  logic                   di_stb,
  input  logic                   reti_stb,
  input  logic                   retire_stb,
  output logic                   ack,
  output logic [IDX_W-1:0]       ack_src,
  output logic                   ie,
  output logic                   svc_valid,
  output prio_t                  svc_level,
  output logic [NSRC-1:0]        pend
);

  logic [NSRC-1:0]  pend_q;
  logic             win_valid;
  logic [IDX_W-1:0] win_idx;
  prio_t            win_prio;
  logic             stk_valid;
  prio_t            stk_level;
  logic             stk_full;
  logic [CNT_W-1:0] stk_depth;
  logic             ie_w;
  logic             hold_w;
  logic             grant_w;
  logic [NSRC-1:0]  clr_w;
  logic             ack_q;
  logic [IDX_W-1:0] ack_src_q;

  nirq_arbiter #(.NSRC(NSRC)) u_arb (
    .pend      (pend_q),
    .mask      (src_mask),
    .prio_flat (src_prio),
    .cur_valid (stk_valid),
    .cur_level (stk_level),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .win_prio  (win_prio)
  );

  // Acknowledge decision for this cycle.
  assign grant_w = win_valid && ie_w && !hold_w && !di_stb && !reti_stb &&
                   !stk_full;

  nirq_level_stack #(.DEPTH(DEPTH)) u_stk (
    .clk        (clk),
    .rst        (rst),
    .push       (grant_w),
    .push_level (win_prio),
    .pop        (reti_stb),
    .top_valid  (stk_valid),
    .top_level  (stk_level),
    .full       (stk_full),
    .depth      (stk_depth)
  );

  nirq_enable_ctrl u_en (
    .clk        (clk),
    .rst        (rst),
    .grant      (grant_w),
    .ei_stb     (ei_stb),
    .di_stb     (di_stb),
    .reti_stb   (reti_stb),
    .retire_stb (retire_stb),
    .ie         (ie_w),
    .hold       (hold_w)
  );

  assign clr_w = grant_w ? (NSRC'(1) << win_idx) : '0;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr_w) | req_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q     <= 1'b0;
      ack_src_q <= '0;
    end else begin
      ack_q <= grant_w;
      if (grant_w) ack_src_q <= win_idx;
    end
  end

  assign ack       = ack_q;
  assign ack_src   = ack_src_q;
  assign ie        = ie_w;
  assign svc_valid = stk_valid;
  assign svc_level = stk_level;
  assign pend      = pend_q;

endmodule

// File: rtl/nirq_chk.sv
module nirq_chk
  import nirq_pkg::*;
#(
  parameter int NSRC  = 8,
  parameter int DEPTH = 4,
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             ack,
  input logic [IDX_W-1:0] ack_src,
  input logic             ie,
  input logic             svc_valid,
  input prio_t            svc_level,
  input logic [NSRC-1:0]  src_mask,
  input logic             di_stb,
  input logic             reti_stb,
  input logic             hold,
  input logic [CNT_W-1:0] depth
);

  // R2
  ack_clears_ie_chk: assert property (@(posedge clk) disable iff (rst)
    ack |-> !ie);

  // R2
  ack_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  // R3
  ack_needs_ie_chk: assert property (@(posedge clk) disable iff (rst)
    ack |-> $past(ie));

  // R4
  nest_strictly_higher_chk: assert property (@(posedge clk) disable iff (rst)
    ack |-> svc_valid && (!$past(svc_valid) || (svc_level < $past(svc_level))));

  // R5
  stack_bound_chk: assert property (@(posedge clk) disable iff (rst)
    depth <= CNT_W'(DEPTH));

  // R6
  reti_enables_chk: assert property (@(posedge clk) disable iff (rst)
    reti_stb && !di_stb |=> ie);

  // R7
  no_ack_at_return_chk: assert property (@(posedge clk) disable iff (rst)
    ack |-> !$past(reti_stb) && !$past(hold));

  // R8
  masked_never_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ack |-> ((($past(src_mask)) >> ack_src) & NSRC'(1)) == '0);

  // R9
  di_clears_ie_chk: assert property (@(posedge clk) disable iff (rst)
    di_stb |=> !ie && !ack);

endmodule

bind nest_irq_ctrl nirq_chk #(.NSRC(NSRC), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ack       (ack),
  .ack_src   (ack_src),
  .ie        (ie),
  .svc_valid (svc_valid),
  .svc_level (svc_level),
  .src_mask  (src_mask),
  .di_stb    (di_stb),
  .reti_stb  (reti_stb),
  .hold      (hold_w),
  .depth     (stk_depth)
);

// File: tb/nest_irq_ctrl_bench.sv
module nest_irq_ctrl_bench;
  localparam int N  = 4;
  localparam int D  = 4;
  localparam int PW = 2;
  localparam int IW = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst = 1'b1;
  logic [N-1:0]    req_set = '0;
  logic [N-1:0]    src_mask = '0;
  logic [N*PW-1:0] src_prio = '1;
  logic            ei_stb = 0, di_stb = 0, reti_stb = 0, retire_stb = 0;
  logic            ack;
  logic [IW-1:0]   ack_src;
  logic            ie, svc_valid;
  logic [PW-1:0]   svc_level;
  logic [N-1:0]    pend;

  int checks = 0;
  int errors = 0;

  nest_irq_ctrl #(.NSRC(N), .DEPTH(D)) u_nest_irq_ctrl (
    .clk(clk), .rst(rst), .req_set(req_set), .src_mask(src_mask),
    .src_prio(src_prio), .ei_stb(ei_stb), .di_stb(di_stb),
    .reti_stb(reti_stb), .retire_stb(retire_stb), .ack(ack),
    .ack_src(ack_src), .ie(ie), .svc_valid(svc_valid),
    .svc_level(svc_level), .pend(pend)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset;
    rst = 1'b1; tick; rst = 1'b0;
  endtask

  task automatic pulse_req(input logic [N-1:0] v);
    req_set = v; tick; req_set = '0;
  endtask

  task automatic pulse_ei;     ei_stb = 1;     tick; ei_stb = 0;     endtask
  task automatic pulse_di;     di_stb = 1;     tick; di_stb = 0;     endtask
  task automatic pulse_reti;   reti_stb = 1;   tick; reti_stb = 0;   endtask
  task automatic pulse_retire; retire_stb = 1; tick; retire_stb = 0; endtask

  task automatic set_prio(input int i, input int v);
    src_prio[i*PW +: PW] = PW'(v);
  endtask

  // Priority configurations used by the arbitration sweep.
  function automatic int cfg_prio(input int c, input int i);
    if (c == 0) return i;
    if (c == 1) return (i < 2) ? 3 : 1;
    return 2;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    tick;
    rst = 1'b0;
    // R10: reset state
    chk("R10 ack", int'(ack), 0);
    chk("R10 ie", int'(ie), 0);
    chk("R10 svc_valid", int'(svc_valid), 0);
    chk("R10 pend", int'(pend), 0);

    // R1 R2 R3 R8 R11: arbitration sweep over all request and mask patterns
    for (int c = 0; c < 3; c++) begin
      for (int pat = 0; pat < 16; pat++) begin
        for (int m = 0; m < 16; m++) begin
          int best_key;
          int best;
          do_reset;
          for (int i = 0; i < N; i++) set_prio(i, cfg_prio(c, i));
          src_mask = N'(m);
          pulse_req(N'(pat));
          chk("R11 pend latched", int'(pend), pat);
          tick;
          chk("R3 no ack while disabled", int'(ack), 0);
          pulse_ei;
          tick;
          best_key = 1000;
          best = -1;
          for (int i = 0; i < N; i++) begin
            int key;
            key = cfg_prio(c, i) * N + i;
            if (pat[i] && !m[i] && key < best_key) begin
              best_key = key;
              best = i;
            end
          end
          chk("R1 ack present", int'(ack), (best >= 0) ? 1 : 0);
          if (best >= 0) begin
            chk("R1 winner", int'(ack_src), best);
            chk("R2 ie cleared", int'(ie), 0);
            chk("R2 R8 pend after ack", int'(pend), pat & ~(1 << best));
          end else begin
            chk("R8 masked flags kept", int'(pend), pat);
            chk("R3 ie set", int'(ie), 1);
          end
        end
      end
    end
    src_mask = '0;

    // R4 R5 R6 R7: nesting over every pair of in-service and new levels
    for (int p = 0; p < 4; p++) begin
      for (int q = 0; q < 4; q++) begin
        do_reset;
        set_prio(0, p); set_prio(1, q); set_prio(2, 3); set_prio(3, 3);
        pulse_req(4'b0001);
        pulse_ei;
        tick;
        chk("R4 first ack", int'(ack), 1);
        chk("R5 level pushed", int'(svc_level), p);
        pulse_req(4'b0010);
        pulse_ei;
        tick;
        chk("R4 nest decision", int'(ack), (q < p) ? 1 : 0);
        if (q < p) begin
          chk("R4 nested source", int'(ack_src), 1);
          chk("R5 nested level", int'(svc_level), q);
          pulse_reti;
          chk("R5 level restored", int'(svc_level), p);
          chk("R5 still in service", int'(svc_valid), 1);
          chk("R6 ie after return", int'(ie), 1);
        end else begin
          chk("R4 held pending", int'(pend[1]), 1);
          chk("R4 level unchanged", int'(svc_level), p);
          pulse_reti;
          chk("R7 no ack at return", int'(ack), 0);
          chk("R6 ie after return", int'(ie), 1);
          chk("R5 back to main", int'(svc_valid), 0);
          tick;
          chk("R7 held before retire", int'(ack), 0);
          pulse_retire;
          chk("R7 no ack at retire edge", int'(ack), 0);
          tick;
          chk("R7 ack after retire", int'(ack), 1);
          chk("R7 pended source", int'(ack_src), 1);
          chk("R5 new level", int'(svc_level), q);
        end
      end
    end

    // R5: four-deep nesting and level restoration
    do_reset;
    for (int i = 0; i < N; i++) set_prio(i, 3 - i);
    for (int k = 0; k < 4; k++) begin
      pulse_req(N'(1 << k));
      pulse_ei;
      tick;
      chk("R5 deep ack", int'(ack), 1);
      chk("R5 deep level", int'(svc_level), 3 - k);
    end
    pulse_req(4'b1000);
    pulse_ei;
    tick;
    chk("R4 equal level at full depth", int'(ack), 0);
    for (int k = 3; k > 0; k--) begin
      pulse_reti;
      chk("R5 unwind level", int'(svc_level), 3 - (k - 1));
    end
    pulse_reti;
    chk("R5 unwind empty", int'(svc_valid), 0);

    // R9: disable strobe precedence
    do_reset;
    pulse_ei;
    chk("R3 ei sets ie", int'(ie), 1);
    pulse_di;
    chk("R9 di clears ie", int'(ie), 0);
    ei_stb = 1; di_stb = 1; tick; ei_stb = 0; di_stb = 0;
    chk("R9 di beats ei", int'(ie), 0);
    set_prio(0, 0);
    pulse_ei;
    pulse_req(4'b0001);
    pulse_di;
    chk("R9 di blocks ack", int'(ack), 0);
    chk("R9 request kept", int'(pend[0]), 1);

    // R10: reset clears pending flags mid-run
    src_mask = '1;
    pulse_req(4'b1111);
    do_reset;
    chk("R10 pend cleared", int'(pend), 0);
    chk("R10 ie cleared", int'(ie), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule